// File: doc/BRIEF.md
# I2C Paired-Register Target Interface

This block is the bus-facing half of a serial port expander. It watches an I2C bus (SCL and SDA) with the system clock, recognises START, repeated START and STOP, and answers one 7-bit target address: four fixed high bits followed by three strap inputs. An address byte with the direction bit at 0 is followed by a command byte whose low three bits select one of eight byte registers. Every later byte goes to that register. The data moves into the register file through a one-cycle write strobe, or out of it through a read strobe. The register file is outside this block.

The eight registers are grouped as four pairs: {0,1}, {2,3}, {4,5} and {6,7}. After every data byte the pointer moves to the partner register of its pair, so a long transfer alternates between two registers and never advances to another pair. A transfer can carry any number of data bytes. Registers 0 and 1 are read-only: bytes written to them are acknowledged, but no write strobe is issued. A read uses the pointer left by the last command byte or by the last transfer. The read strobe is raised in the cycle the byte is loaded for transmission, so the port logic can take a snapshot of the register at that moment.

The bus is modelled as open drain. The block pulls SDA low by raising `sda_oe_o` and never drives it high.

Top module: `i2c_pair_target`

## Requirements
- R1: After reset `sda_oe_o`, `wr_en_o` and `rd_en_o` are low and the register pointer is 0, so a read issued with no command byte returns register 0 and then register 1.
- R2: The target pulls SDA low in the acknowledge bit of an address byte whose seven high bits are 0100 followed by `strap_i[2:0]`. The low bit of that byte is the direction: 0 for write, 1 for read.
- R3: For any other address the acknowledge bit is left high. The target then gives no acknowledge, issues no strobe and does not drive SDA until the next START.
- R4: In a write transfer, the first byte after the address is a command byte. Its bits [2:0] load the pointer, bits [7:3] are ignored, and the byte is acknowledged.
- R5: Each data byte that follows is acknowledged. If the pointer is 2 to 7, the byte produces exactly one `wr_en_o` pulse carrying `wr_idx_o` equal to the pointer and `wr_data_o` equal to the byte. Bus bits arrive MSB first.
- R6: After every data byte, written or read, the pointer changes to pointer XOR 1 (3 goes to 2, 2 goes to 3, and so on). The number of bytes in a transfer is not limited.
- R7: Bytes written while the pointer is 0 or 1 are acknowledged but produce no write strobe.
- R8: In a read transfer the target raises `rd_en_o` for one cycle with `rd_idx_o` equal to the register being loaded, and takes `rd_data_i` in that same cycle. It shifts the byte out MSB first. When the master acknowledges, the next byte comes from the partner register.
- R9: When the master does not acknowledge a read byte, the target releases SDA, issues no further read strobe and leaves SDA high until the next START.
- R10: A STOP at any point releases SDA within one cycle of its detection and drops any partial byte. The pointer keeps its value for the next transfer.
- R11: A START or repeated START at any point releases SDA and restarts address decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Low three bits of the target address |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_idx_o | output | 3 | Register index for the write |
| wr_data_o | output | 8 | Write data byte |
| rd_en_o | output | 1 | One-cycle register read strobe |
| rd_idx_o | output | 3 | Register index for the read |
| rd_data_i | input | 8 | Register contents, valid in the cycle `rd_en_o` is high |

## Verification
A wrong pointer appears at the next write strobe as a wrong `wr_idx_o`, or as the wrong byte in the next read. Either shows up within one byte time of the faulty update. A state machine that stays in a driving state shows as `sda_oe_o` held high past a STOP or START, or as SDA pulled low after a master NACK. The master sees this in the next bit period. A broken address compare shows as a missing acknowledge, or as an acknowledge that should not be there, in the ninth bit of the address byte.

// File: rtl/i2c_pair_pkg.sv
package i2c_pair_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} eng_st_e;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} rx_kind_e;

  // registers 0/1 are read-only
  function automatic logic idx_writable(input logic [IDX_W-1:0] idx);
    return idx[IDX_W-1:1] != '0;
  endfunction
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_pair_ptr.sv
module i2c_pair_ptr
  import i2c_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             flip_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (flip_i) ptr_q <= {ptr_q[IDX_W-1:1], ~ptr_q[0]};
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_pair_engine.sv
module i2c_pair_engine
  import i2c_pair_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic [IDX_W-1:0]  ptr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              ptr_load_o,
  output logic [IDX_W-1:0]  ptr_val_o,
  output logic              ptr_flip_o,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o
);
  eng_st_e           st_q;
  rx_kind_e          kind_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] rx_sh_q, tx_sh_q, wr_data_q;
  logic [IDX_W-1:0]  wr_idx_q;
  logic              rw_q, more_q, sda_oe_q, wr_en_q;

  logic [BYTE_W-1:0] rx_byte;
  logic              byte_end, addr_hit, load_first, load_next;

  assign rx_byte    = {rx_sh_q[BYTE_W-2:0], sda_s_i};
  assign byte_end   = (st_q == ST_RX) && scl_rise_i && (bit_cnt_q == CNT_W'(BYTE_W - 1));
  assign addr_hit   = rx_byte[BYTE_W-1:1] == {ADDR_HI, strap_i};
  assign load_first = byte_end && (kind_q == K_ADDR) && addr_hit && rx_byte[0];
  assign load_next  = (st_q == ST_MACK) && scl_rise_i && !sda_s_i;

  // read strobe coincides with capture of rd_data_i
  assign rd_en_o    = load_first || load_next;
  assign rd_idx_o   = load_next ? {ptr_i[IDX_W-1:1], ~ptr_i[0]} : ptr_i;
  assign ptr_load_o = byte_end && (kind_q == K_CMD);
  assign ptr_val_o  = rx_byte[IDX_W-1:0];
  assign ptr_flip_o = (byte_end && (kind_q == K_DATA)) || ((st_q == ST_MACK) && scl_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= K_ADDR;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      rw_q      <= 1'b0;
      more_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_RX;
        kind_q    <= K_ADDR;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
        more_q    <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_q <= 1'b0;
        more_q   <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise_i) begin
              rx_sh_q   <= rx_byte;
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (byte_end) begin
              unique case (kind_q)
                K_ADDR: begin
                  if (addr_hit) begin
                    rw_q <= rx_byte[0];
                    if (rx_byte[0]) tx_sh_q <= rd_data_i;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                K_CMD: ;
                K_DATA: begin
                  wr_en_q   <= idx_writable(ptr_i);
                  wr_idx_q  <= ptr_i;
                  wr_data_q <= rx_byte;
                end
                default: ;
              endcase
            end
            if (scl_fall_i && bit_cnt_q == CNT_W'(BYTE_W)) begin
              sda_oe_q <= 1'b1;
              st_q     <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (kind_q == K_ADDR && rw_q) begin
                st_q     <= ST_TX;
                sda_oe_q <= ~tx_sh_q[BYTE_W-1];
              end else begin
                st_q     <= ST_RX;
                sda_oe_q <= 1'b0;
                kind_q   <= (kind_q == K_ADDR) ? K_CMD : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) bit_cnt_q <= bit_cnt_q + 1'b1;
            if (scl_fall_i) begin
              if (bit_cnt_q == CNT_W'(BYTE_W)) begin
                sda_oe_q <= 1'b0;
                st_q     <= ST_MACK;
              end else begin
                tx_sh_q  <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                sda_oe_q <= ~tx_sh_q[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              if (!sda_s_i) begin
                tx_sh_q <= rd_data_i;
                more_q  <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
            if (scl_fall_i && more_q) begin
              more_q    <= 1'b0;
              bit_cnt_q <= '0;
              st_q      <= ST_TX;
              sda_oe_q  <= ~tx_sh_q[BYTE_W-1];
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/i2c_pair_target.sv
module i2c_pair_target
  import i2c_pair_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b0100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  output logic       wr_en_o,
  output logic [2:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic       rd_en_o,
  output logic [2:0] rd_idx_o,
  input  logic [7:0] rd_data_i
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             ptr_load, ptr_flip;
  logic [IDX_W-1:0] ptr_val, ptr;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_pair_ptr u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_val),
    .flip_i     (ptr_flip),
    .ptr_o      (ptr)
  );

  i2c_pair_engine #(.ADDR_HI(ADDR_HI)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .strap_i    (strap_i),
    .ptr_i      (ptr),
    .rd_data_i  (rd_data_i),
    .ptr_load_o (ptr_load),
    .ptr_val_o  (ptr_val),
    .ptr_flip_o (ptr_flip),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o),
    .rd_en_o    (rd_en_o),
    .rd_idx_o   (rd_idx_o)
  );
endmodule

// File: rtl/i2c_pair_target_chk.sv
module i2c_pair_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic       wr_en_o,
  input logic [2:0] wr_idx_o,
  input logic       rd_en_o,
  input logic       start_det,
  input logic       stop_det
);
  a_r7_no_input_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o[2:1] != 2'b00));

  a_r5_wr_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  a_r8_rd_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);

  a_r10_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  a_r11_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);
endmodule

bind i2c_pair_target i2c_pair_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_oe_o  (sda_oe_o),
  .wr_en_o   (wr_en_o),
  .wr_idx_o  (wr_idx_o),
  .rd_en_o   (rd_en_o),
  .start_det (start_det),
  .stop_det  (stop_det)
);

// File: tb/i2c_pair_target_tb_top.sv
module i2c_pair_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b011;
  logic sda_oe, wr_en, rd_en, sda_w;
  logic [2:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  logic [7:0] port_reg [8];
  logic [7:0] ref_reg [8];
  logic [2:0] ref_ptr;
  logic [10:0] exp_q [$];
  int n_chk = 0, n_err = 0, rd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_w   = sda_m & ~sda_oe;
  assign rd_data = port_reg[rd_idx];

  i2c_pair_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .strap_i(strap), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_en_o(rd_en), .rd_idx_o(rd_idx), .rd_data_i(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // monitor: scoreboard of write strobes, read strobe count, device-side register store
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5/R7 unexpected write", {21'd0, wr_idx, wr_data}, 32'h0);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          check({wr_idx, wr_data} == e, "R5 write strobe", {21'd0, wr_idx, wr_data}, {21'd0, e});
        end
        port_reg[wr_idx] = wr_data;
      end
      if (rd_en) rd_cnt++;
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q); scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b1; wait_q(Q); sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic put_bit(input logic v);
    wait_q(Q); sda_m = v; wait_q(Q); scl_m = 1'b1; wait_q(2*Q); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic v);
    wait_q(1); sda_m = 1'b1; wait_q(2*Q); scl_m = 1'b1; wait_q(Q);
    v = sda_w; wait_q(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(v);
    ack = !v;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic v;
      get_bit(v);
      b[i] = v;
    end
    put_bit(!mack);
  endtask

  function automatic logic [7:0] addr_byte(input logic rw);
    return {4'b0100, strap, rw};
  endfunction

  // driver: full write transfer, pushes expected strobes
  task automatic write_regs(input logic [7:0] cmd, input logic [7:0] d [8], input int n, input string req);
    logic ack;
    bus_start();
    send_byte(addr_byte(1'b0), ack);
    check(ack, "R2 address ack (write)", {31'd0, ack}, 1);
    send_byte(cmd, ack);
    check(ack, "R4 command ack", {31'd0, ack}, 1);
    ref_ptr = cmd[2:0];
    for (int i = 0; i < n; i++) begin
      if (ref_ptr[2:1] != 2'b00) begin
        exp_q.push_back({ref_ptr, d[i]});
        ref_reg[ref_ptr] = d[i];
      end
      send_byte(d[i], ack);
      check(ack, req, {31'd0, ack}, 1);
      ref_ptr[0] = ~ref_ptr[0];
    end
    bus_stop();
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // read transfer, optional command byte then repeated START
  task automatic read_regs(input bit use_cmd, input logic [2:0] cmd, input int n, input string req);
    logic ack;
    logic [7:0] b;
    int rd0;
    bus_start();
    if (use_cmd) begin
      send_byte(addr_byte(1'b0), ack);
      check(ack, "R2 address ack", {31'd0, ack}, 1);
      send_byte({5'b0, cmd}, ack);
      check(ack, "R4 command ack", {31'd0, ack}, 1);
      ref_ptr = cmd;
      bus_start();
    end
    rd0 = rd_cnt;
    send_byte(addr_byte(1'b1), ack);
    check(ack, "R2 address ack (read)", {31'd0, ack}, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(b == ref_reg[ref_ptr], req, b, ref_reg[ref_ptr]);
      ref_ptr[0] = ~ref_ptr[0];
    end
    check(rd_cnt - rd0 == n, "R8 read strobe count", rd_cnt - rd0, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic ack, v;
    logic [7:0] d [8];
    int rd0;
    ref_reg[0] = 8'hA5; ref_reg[1] = 8'h3C;
    ref_reg[2] = 8'hFF; ref_reg[3] = 8'hFF;
    ref_reg[4] = 8'h00; ref_reg[5] = 8'h00;
    ref_reg[6] = 8'hFF; ref_reg[7] = 8'hFF;
    for (int i = 0; i < 8; i++) port_reg[i] = ref_reg[i];
    ref_ptr = 3'd0;
    wait_q(5);
    check(sda_oe == 1'b0 && wr_en == 1'b0 && rd_en == 1'b0, "R1 reset outputs",
          {29'd0, sda_oe, wr_en, rd_en}, 0);
    rst_n = 1'b1;
    wait_q(5);

    // R1: pointer starts at 0
    read_regs(1'b0, 3'd0, 2, "R1 R8 read after reset");
    bus_stop();

    // R5 R6: long transfer alternating 3,2
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h01};
    write_regs(8'h03, d, 7, "R6 pair toggle write");
    // R4: upper command bits ignored (0xF4 -> register 4)
    d = '{8'h0F, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    write_regs(8'hF4, d, 2, "R4 R5 polarity write");
    // R7: read-only registers
    d = '{8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    write_regs(8'h00, d, 3, "R7 write to input regs acked");
    read_regs(1'b1, 3'd0, 2, "R7 input regs unchanged");
    bus_stop();

    // R8 R9: read 3,2,3 then NACK
    read_regs(1'b1, 3'd3, 3, "R8 R6 pair toggle read");
    rd0 = rd_cnt;
    wait_q(2*Q);
    check(sda_oe == 1'b0, "R9 release after NACK", {31'd0, sda_oe}, 0);
    get_bit(v);
    check(v == 1'b1, "R9 no drive after NACK", {31'd0, v}, 1);
    check(rd_cnt == rd0, "R9 no read strobe after NACK", rd_cnt, rd0);
    bus_stop();

    // R10: pointer retained across transfers
    read_regs(1'b0, 3'd0, 2, "R10 read with retained pointer");
    bus_stop();
    read_regs(1'b1, 3'd4, 2, "R5 polarity readback");
    bus_stop();

    // R3: wrong address, then R11 repeated START with correct address
    bus_start();
    send_byte({4'b0100, ~strap, 1'b0}, ack);
    check(!ack, "R3 no ack on mismatch", {31'd0, ack}, 0);
    send_byte(8'h06, ack);
    check(!ack, "R3 bus ignored after mismatch", {31'd0, ack}, 0);
    send_byte(8'hC3, ack);
    check(!ack && exp_q.size() == 0, "R3 no strobe after mismatch", {31'd0, ack}, 0);
    bus_start();
    send_byte(addr_byte(1'b0), ack);
    check(ack, "R11 repeated START restarts address", {31'd0, ack}, 1);
    send_byte(8'h06, ack);
    ref_ptr = 3'd6;
    exp_q.push_back({3'd6, 8'h5A});
    ref_reg[6] = 8'h5A;
    send_byte(8'h5A, ack);
    ref_ptr = 3'd7;
    check(ack, "R11 data ack", {31'd0, ack}, 1);

    // R10: STOP in the middle of a byte after a new command 7
    bus_start();
    send_byte(addr_byte(1'b0), ack);
    send_byte(8'h07, ack);
    ref_ptr = 3'd7;
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    wait_q(Q);
    check(sda_oe == 1'b0 && exp_q.size() == 0, "R10 STOP mid-byte drops byte", {31'd0, sda_oe}, 0);
    read_regs(1'b0, 3'd0, 2, "R10 pointer kept after partial byte");
    bus_stop();

    // R2: different strap value
    strap = 3'b110;
    d = '{8'h9C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    write_regs(8'h02, d, 1, "R2 new strap write");
    read_regs(1'b1, 3'd2, 4, "R2 new strap read");
    bus_stop();

    wait_q(4*Q);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule